// File: doc/BRIEF.md
# Burst-Write I2C Master

This block is an I2C bus master that writes a burst of one to four bytes to a slave in one transaction. Software loads a 32-bit transmit word and a prescaler value. It then writes the control register with a start command and a byte count. The core issues a START condition, shifts the bytes out, checks the acknowledge after each byte, and closes with a STOP. The burst ends early if the slave answers NACK. Progress and results appear on plain status outputs. A level interrupt is raised when the transfer ends or when arbitration is lost.

The bus pins are open-drain. Each output port is a pull-low enable, and the bus levels come back in through two input ports. While the core is disabled, two software bits drive the lines directly, so firmware can bit-bang the bus. A monitor on the synchronised bus levels tracks START and STOP conditions from any master. It keeps a bus-busy flag and detects loss of arbitration.

Top module: `i2cm_burst_tx`

## Requirements
- R1: The byte-count field is written with the number of bytes minus one (0 = one byte, 3 = four bytes). The remaining-count status starts at that value, drops by one after each acknowledged byte that has a successor, and reads 0 after a complete burst.
- R2: After START the core sends the transmit word (register address 2) highest byte first, each byte MSB first, with one acknowledge clock after every byte.
- R3: A NACK on any byte ends the burst after that byte. A STOP condition is still generated, and the remaining count keeps the value it had on that byte.
- R4: The acknowledge status reads 0 when the last acknowledge bit was ACK and 1 when it was NACK.
- R5: The bus-busy status becomes 1 after a START condition (SDA falling while SCL is high) is seen on the bus inputs, and 0 after a STOP condition (SDA rising while SCL is high).
- R6: Arbitration is lost when the core releases SDA for a 1 bit but samples it low, or when a STOP it did not generate is seen. The core then releases both lines, generates no STOP, returns to idle and sets the lost status. That status clears on the next start command.
- R7: The interrupt flag sets when a transfer ends (complete or NACK) or arbitration is lost. It clears when 1 is written to control bit 3. The irq output is the flag gated by control bit 1.
- R8: While a transfer is in progress, register writes are ignored, except a write to address 3 with bit 0 set. That write resets all registers and aborts the transfer, which releases both lines.
- R9: With control bit 0 (core enable) at 0, SCL is pulled low exactly when control bit 6 is 0, and SDA is pulled low exactly when control bit 7 is 0. Both bits reset to 1.
- R10: Each bus bit lasts four quarter steps of max(prescaler, 4) clock cycles each, so the SCL period is four times that. SDA driven by the core changes only while SCL is held low in data and acknowledge bits.
- R11: Control (address 0) bits: 0 enable, 1 interrupt enable, 2 start command (needs bit 0 set in the same write, self-clearing), 3 flag clear, 5:4 byte count, 6 and 7 bit-bang SCL and SDA. The prescaler is at address 1, bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Register write data |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Interrupt request |
| st_tip | output | 1 | Transfer in progress |
| st_busy | output | 1 | Bus busy |
| st_lost | output | 1 | Arbitration lost |
| st_nack | output | 1 | Last acknowledge was NACK |
| st_if | output | 1 | Interrupt flag |
| st_left | output | 2 | Remaining-byte count |

## Verification
A register write takes effect at the clock edge that samples it, and the start command raises st_tip at that same edge. Pin outputs follow one cycle later. Bus inputs reach the status bits about three cycles after a line changes. The flag and interrupt settle two cycles after st_tip falls. For these reasons the bench waits for st_tip to fall and then lets four more falling clock edges pass before it compares results. It measures the SCL period between pull-enable releases, and waits five cycles after each bit-bang write before reading st_busy. A slave model on the bench's open-drain wires captures the bytes, answers ACK or NACK per byte, and can jam SDA to force arbitration loss.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_START, PH_BIT, PH_ACK, PH_STOP} phase_e;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_PRESC = 2'd1;
  localparam logic [1:0] A_TXD   = 2'd2;
  localparam logic [1:0] A_SRST  = 2'd3;

  localparam int CB_EN    = 0;
  localparam int CB_IE    = 1;
  localparam int CB_GO    = 2;
  localparam int CB_IFC   = 3;
  localparam int CB_CNT   = 4;
  localparam int CB_BBSCL = 6;
  localparam int CB_BBSDA = 7;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int PW   = 16,
  parameter int MINQ = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  localparam logic [PW-1:0] MINV = PW'(MINQ);

  logic [PW-1:0] lim;
  logic [PW-1:0] cnt;

  assign lim  = (presc < MINV) ? MINV : presc;
  assign tick = run && (cnt == lim - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic scl_m, scl_s, sda_m, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

  a_r5_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  a_r5_free_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          go,
  input  logic [CW-1:0] go_cnt,
  input  logic [DW-1:0] tx_data,
  input  logic          tick,
  input  logic          sda_s,
  input  logic          stop_det,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          rx_nack,
  output logic          done_p,
  output logic          lost_p
);
  localparam int BITW = 3;

  phase_e          state;
  logic [1:0]      q;
  logic [BITW-1:0] bitn;
  logic [DW-1:0]   sh;
  logic            dscl, dsda, dphase_q;

  assign busy = (state != PH_IDLE);

  always_comb begin
    dscl = 1'b0;
    dsda = 1'b0;
    unique case (state)
      PH_START: begin dsda = (q != 2'd0); dscl = (q == 2'd3); end
      PH_BIT:   begin dsda = ~sh[DW-1];   dscl = (q == 2'd0) || (q == 2'd3); end
      PH_ACK:   begin dscl = (q == 2'd0) || (q == 2'd3); end
      PH_STOP:  begin dscl = (q == 2'd0); dsda = (q < 2'd2); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0; sda_oe <= 1'b0; dphase_q <= 1'b0;
    end else if (clr) begin
      scl_oe <= 1'b0; sda_oe <= 1'b0; dphase_q <= 1'b0;
    end else begin
      scl_oe   <= dscl;
      sda_oe   <= dsda;
      dphase_q <= (state == PH_BIT) || (state == PH_ACK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE; q <= '0; bitn <= '0; sh <= '0; cnt <= '0;
      rx_nack <= 1'b0; done_p <= 1'b0; lost_p <= 1'b0;
    end else if (clr) begin
      state <= PH_IDLE; q <= '0; bitn <= '0; sh <= '0; cnt <= '0;
      rx_nack <= 1'b0; done_p <= 1'b0; lost_p <= 1'b0;
    end else begin
      done_p <= 1'b0;
      lost_p <= 1'b0;
      if (state == PH_IDLE) begin
        if (go) begin
          state <= PH_START;
          q     <= '0;
          sh    <= tx_data;
          cnt   <= go_cnt;
        end
      end else if (stop_det && state != PH_STOP) begin
        state  <= PH_IDLE;
        lost_p <= 1'b1;
      end else if (tick) begin
        if (state == PH_BIT && q == 2'd2 && sh[DW-1] && !sda_s) begin
          state  <= PH_IDLE;
          lost_p <= 1'b1;
        end else if (q != 2'd3) begin
          if (state == PH_ACK && q == 2'd2) rx_nack <= sda_s;
          q <= q + 2'd1;
        end else begin
          q <= '0;
          unique case (state)
            PH_START: begin state <= PH_BIT; bitn <= '1; end
            PH_BIT: begin
              sh <= {sh[DW-2:0], 1'b0};
              if (bitn == '0) state <= PH_ACK;
              else            bitn  <= bitn - BITW'(1);
            end
            PH_ACK: begin
              if (rx_nack || cnt == '0) state <= PH_STOP;
              else begin
                cnt   <= cnt - CW'(1);
                state <= PH_BIT;
                bitn  <= '1;
              end
            end
            PH_STOP: begin state <= PH_IDLE; done_p <= 1'b1; end
            default: state <= PH_IDLE;
          endcase
        end
      end
    end
  end

  a_r1_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n || clr)
    busy && $past(busy) |-> cnt <= $past(cnt));
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n || clr)
    dphase_q && $past(dphase_q) && !$stable(sda_oe) |-> scl_oe && $past(scl_oe));
endmodule

// File: rtl/i2cm_burst_tx.sv
module i2cm_burst_tx
  import i2cm_pkg::*;
#(
  parameter int          PRESC_W   = 16,
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 2,
  parameter int          MIN_Q     = 4,
  parameter int          PRESC_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              st_tip,
  output logic              st_busy,
  output logic              st_lost,
  output logic              st_nack,
  output logic              st_if,
  output logic [CNT_W-1:0]  st_left
);
  localparam logic [PRESC_W-1:0] PRST = PRESC_W'(PRESC_RST);

  logic en_q, ie_q, bbscl_q, bbsda_q, if_q, lost_q;
  logic [PRESC_W-1:0] presc_q;
  logic [DATA_W-1:0]  txd_q;
  logic wr_ok, srst, go, tick;
  logic e_scl, e_sda, e_busy, e_done, e_lost, sda_s, start_det, stop_det;

  assign wr_ok = wr_en && (!e_busy || wr_addr == A_SRST);
  assign srst  = wr_ok && wr_addr == A_SRST && wr_data[0];
  assign go    = wr_ok && wr_addr == A_CTRL && wr_data[CB_GO] && wr_data[CB_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ie_q <= 1'b0; bbscl_q <= 1'b1; bbsda_q <= 1'b1;
      if_q <= 1'b0; lost_q <= 1'b0; presc_q <= PRST; txd_q <= '0;
    end else if (srst) begin
      en_q <= 1'b0; ie_q <= 1'b0; bbscl_q <= 1'b1; bbsda_q <= 1'b1;
      if_q <= 1'b0; lost_q <= 1'b0; presc_q <= PRST; txd_q <= '0;
    end else begin
      if (wr_ok && wr_addr == A_CTRL) begin
        en_q    <= wr_data[CB_EN];
        ie_q    <= wr_data[CB_IE];
        bbscl_q <= wr_data[CB_BBSCL];
        bbsda_q <= wr_data[CB_BBSDA];
        if (wr_data[CB_IFC]) if_q <= 1'b0;
      end
      if (wr_ok && wr_addr == A_PRESC) presc_q <= wr_data[PRESC_W-1:0];
      if (wr_ok && wr_addr == A_TXD)   txd_q   <= wr_data;
      if (go)                lost_q <= 1'b0;
      if (e_lost)            lost_q <= 1'b1;
      if (e_done || e_lost)  if_q   <= 1'b1;
    end
  end

  i2cm_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det), .busy(st_busy)
  );

  i2cm_qtick #(.PW(PRESC_W), .MINQ(MIN_Q)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(e_busy), .presc(presc_q), .tick(tick)
  );

  i2cm_engine #(.DW(DATA_W), .CW(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst), .go(go),
    .go_cnt(wr_data[CB_CNT +: CNT_W]), .tx_data(txd_q), .tick(tick),
    .sda_s(sda_s), .stop_det(stop_det), .scl_oe(e_scl), .sda_oe(e_sda),
    .busy(e_busy), .cnt(st_left), .rx_nack(st_nack), .done_p(e_done), .lost_p(e_lost)
  );

  assign scl_oe  = en_q ? e_scl : ~bbscl_q;
  assign sda_oe  = en_q ? e_sda : ~bbsda_q;
  assign irq     = if_q && ie_q;
  assign st_tip  = e_busy;
  assign st_lost = lost_q;
  assign st_if   = if_q;

  a_r7_flag_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_busy) && !$past(srst) |=> if_q);
  a_r6_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n || srst)
    $rose(lost_q) |=> !scl_oe && !sda_oe);
  a_r8_txd_held: assert property (@(posedge clk) disable iff (!rst_n)
    e_busy && $past(e_busy) |-> $stable(txd_q));
endmodule

// File: tb/i2cm_burst_tx_tb_top.sv
module i2cm_burst_tx_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en;
  logic [1:0] wr_addr;
  logic [31:0] wr_data;
  logic scl_oe, sda_oe, irq, st_tip, st_busy, st_lost, st_nack, st_if;
  logic [1:0] st_left;
  logic slv_low = 1'b0, jam_low = 1'b0, jam_arm = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_low || jam_low);

  i2cm_burst_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .st_tip(st_tip), .st_busy(st_busy), .st_lost(st_lost), .st_nack(st_nack),
    .st_if(st_if), .st_left(st_left)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // slave model on the open-drain wires
  logic prev_scl = 1'b1, prev_sda = 1'b1, in_frame = 1'b0;
  int bitn = 0, byten = 0, nack_at = 99, stops = 0;
  logic [7:0] cur = 8'h0;
  logic [7:0] got [0:7];

  always @(scl_line or sda_line) begin
    if (scl_line && prev_scl && prev_sda && !sda_line) begin
      in_frame = 1'b1; bitn = 0; byten = 0;
    end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
      in_frame = 1'b0; stops = stops + 1;
    end else if (scl_line && !prev_scl && in_frame) begin
      if (bitn < 8) begin
        cur = {cur[6:0], sda_line};
        bitn = bitn + 1;
        if (bitn == 8 && byten < 8) got[byten] = cur;
      end else if (bitn == 8) bitn = 9;
    end else if (!scl_line && prev_scl && in_frame) begin
      if (jam_arm && byten == 0 && bitn == 1) jam_low = 1'b1;
      if (bitn == 8) slv_low = (byten != nack_at);
      else if (bitn == 9) begin slv_low = 1'b0; bitn = 0; byten = byten + 1; end
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // SCL period monitor, measured between releases of the SCL pull
  int pctr = 0, period = 0;
  logic pprev = 1'b0;
  always @(negedge clk) begin
    pctr = pctr + 1;
    if (pprev && !scl_oe) begin period = pctr; pctr = 0; end
    pprev = scl_oe;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!st_tip) begin ok = 1; break; end
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] d, input int k);
    return 8'((d >> (24 - 8 * k)) & 32'hFF);
  endfunction

  function automatic int exp_left(input int n, input int nk);
    return (nk < n) ? (n - 1 - nk) : 0;
  endfunction

  function automatic logic [31:0] ctrl(input int n, input bit ie, input bit gob);
    return 32'hC9 | (32'(n - 1) << 4) | (32'(ie) << 1) | (32'(gob) << 2);
  endfunction

  task automatic xfer(input logic [31:0] d, input int n, input int nk, input int p,
                      input bit ie, input bit poke);
    bit ok, nacked;
    int s0, en_bytes, qq;
    nack_at = nk;
    s0 = stops;
    wr(2'd1, 32'(p));
    wr(2'd2, d);
    wr(2'd0, ctrl(n, ie, 1'b1));
    chk(st_lost == 1'b0, "R6 lost clears on start", st_lost, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      wr(2'd2, ~d);
      wr(2'd0, 32'h0);
    end
    wait_idle(ok);
    chk(ok, "R8 transfer finishes", ok, 1);
    repeat (4) @(negedge clk);
    nacked = (nk < n);
    en_bytes = nacked ? nk + 1 : n;
    chk(byten == en_bytes, "R3 bytes sent", byten, en_bytes);
    for (int k = 0; k < en_bytes; k++)
      chk(got[k] == exp_byte(d, k), poke ? "R8 data unchanged by write" : "R2 byte order",
          got[k], exp_byte(d, k));
    chk(st_left == 2'(exp_left(n, nk)), "R1 remaining count", st_left, exp_left(n, nk));
    chk(st_nack == nacked, "R4 ack status", st_nack, nacked);
    chk(stops == s0 + 1, "R3 stop generated", stops, s0 + 1);
    chk(st_if == 1'b1, "R7 flag set", st_if, 1);
    chk(irq == ie, "R7 irq gate", irq, ie);
    chk(st_busy == 1'b0, "R5 busy after stop", st_busy, 0);
    qq = (p < 4) ? 4 : p;
    chk(period == 4 * qq, "R10 scl period", period, 4 * qq);
    wr(2'd0, ctrl(1, ie, 1'b0));
    @(negedge clk);
    chk(st_if == 1'b0 && irq == 1'b0, "R7 flag clear", st_if, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int sd;
    sd = $urandom(32'd7715);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!st_tip && !st_if && !irq && !st_lost && st_left == 0 && !st_nack,
        "R11 reset status", {st_tip, st_if, irq, st_lost}, 0);
    chk(!scl_oe && !sda_oe, "R9 reset lines released", {scl_oe, sda_oe}, 0);

    // bit-bang with core disabled; also drives START/STOP for the busy flag
    wr(2'd0, 32'h40);
    repeat (5) @(negedge clk);
    chk(sda_oe && !scl_oe, "R9 bitbang sda low", {scl_oe, sda_oe}, 1);
    chk(st_busy == 1'b1, "R5 busy on start", st_busy, 1);
    wr(2'd0, 32'h00);
    chk(scl_oe && sda_oe, "R9 bitbang scl low", {scl_oe, sda_oe}, 3);
    wr(2'd0, 32'h40);
    wr(2'd0, 32'hC0);
    repeat (5) @(negedge clk);
    chk(st_busy == 1'b0, "R5 idle on stop", st_busy, 0);

    // directed bursts
    xfer(32'hA5C3_0F96, 4, 99, 6, 1'b1, 1'b0);
    xfer(32'h1234_5678, 4, 1, 5, 1'b1, 1'b0);
    xfer(32'hFFEE_0180, 3, 2, 2, 1'b0, 1'b0);
    xfer(32'h8001_7E3C, 1, 0, 4, 1'b1, 1'b0);
    xfer(32'h6B2D_94C1, 4, 99, 6, 1'b1, 1'b1);

    // soft reset during a transfer (R8)
    nack_at = 99;
    wr(2'd1, 32'd5);
    wr(2'd2, 32'hC3C3_C3C3);
    wr(2'd0, ctrl(4, 1'b1, 1'b1));
    repeat (60) @(negedge clk);
    wr(2'd3, 32'h1);
    chk(!st_tip && !scl_oe && !sda_oe, "R8 soft reset aborts", {st_tip, scl_oe, sda_oe}, 0);
    chk(!st_if && st_left == 0, "R8 soft reset clears", {st_if, st_left}, 0);
    repeat (20) @(negedge clk);

    // arbitration loss by a jammed SDA (R6)
    jam_arm = 1'b1;
    wr(2'd1, 32'd5);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, ctrl(2, 1'b1, 1'b1));
    wait_idle(ok);
    repeat (3) @(negedge clk);
    chk(ok && st_lost, "R6 lost flag", st_lost, 1);
    chk(st_if && irq, "R7 flag on loss", {st_if, irq}, 3);
    chk(!scl_oe && !sda_oe, "R6 lines released", {scl_oe, sda_oe}, 0);
    ok = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sda_oe || scl_oe) ok = 0;
    end
    chk(ok, "R6 no stop driven", ok, 1);
    jam_arm = 1'b0;
    jam_low = 1'b0;
    repeat (10) @(negedge clk);
    wr(2'd0, ctrl(1, 1'b1, 1'b0));

    // random bursts
    for (int it = 0; it < 12; it++) begin
      logic [31:0] d;
      int n, nk, p;
      bit ie;
      d = $urandom;
      n = $urandom_range(1, 4);
      nk = $urandom_range(0, 5);
      p = $urandom_range(1, 7);
      ie = 1'($urandom_range(0, 1));
      xfer(d, n, nk, p, ie, 1'b0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule